// File: doc/BRIEF.md
# HDLC Event Status and Interrupt Mask Unit

This unit gathers single-cycle event pulses from an HDLC link's transmitter, receiver and FIFOs into an 8-bit sticky status register. An 8-bit enable register selects which of those events may raise the single active-high interrupt line. A processor uses a small register port to do three things: write and read back the enable register, read the status register, and clear the status register by reading it.

One status position is shared between two sources. A select input decides whether that position records a received frame abort or a transmit FIFO underrun. An underrun here means the transmitter tried to take a byte from an empty FIFO. Events that are disabled in the enable register still set their status bits, so software can poll for them without taking interrupts.

The unit has no state machine. Each status bit is an independent sticky flag with three actions: hold, set or clear. The interrupt line is driven combinationally from the registered status and enable values. It therefore has no states or transitions of its own.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: After reset, the status register and the enable register are both 0x00, and `irq` is low.
- R2: An event pulse in cycle N sets its status bit, visible after the clock edge that ends cycle N. The bit positions are: 7 go-ahead seen, 6 receive end-of-packet, 5 transmit end-of-packet, 4 end-of-packet read, 3 transmit FIFO low, 2 shared abort/underrun, 1 receive FIFO full, 0 receive FIFO overflow.
- R3: When `src_sel` is 0, status bit 2 is set by `ev_pulse[2]` (frame abort), and `ev_tx_underrun` has no effect.
- R4: When `src_sel` is 1, status bit 2 is set by `ev_tx_underrun`, and `ev_pulse[2]` has no effect.
- R5: A read with `reg_addr`=1 (status) returns the status value held before the read on `reg_rdata` in the same cycle. All status bits are clear after that edge.
- R6: An event that arrives in the same cycle as a status read leaves its bit set after the read.
- R7: A write with `reg_addr`=0 loads `reg_wdata` into the enable register, and a read with `reg_addr`=0 returns it. A 0 in an enable bit disables that source.
- R8: An event whose enable bit is 0 still sets its status bit but does not raise `irq`.
- R9: `irq` is high exactly when some status bit and its enable bit are both 1. It stays high until a status read clears those bits.
- R10: A write to the status address does not change the status register, and a read of the enable register does not clear the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_pulse | input | 8 | Event pulses, bit layout as in R2; bit 2 is frame abort |
| ev_tx_underrun | input | 1 | Transmit FIFO underrun pulse |
| src_sel | input | 1 | Selects the source for status bit 2 (0 abort, 1 underrun) |
| reg_addr | input | 1 | Register select: 0 enable, 1 status |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that every event input is a pulse sampled on the same clock, and that `reg_rd` and `reg_wr` are never high in the same cycle. The stimulus drives all inputs well away from the rising edge and holds each strobe for one cycle only. It never raises both strobes together. Coincident event-and-read cycles are created on purpose, so the sticky rules are exercised exactly at the clear edge.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
    localparam int unsigned STAT_W     = 8;
    localparam int unsigned SHARED_BIT = 2;
    localparam int unsigned ADDR_W     = 1;

    typedef logic [STAT_W-1:0] stat_vec_t;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b1;
endpackage

// File: rtl/hdlc_irq_src_mux.sv
module hdlc_irq_src_mux
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned W       = STAT_W,
    parameter int unsigned SHARE_B = SHARED_BIT
) (
    input  logic [W-1:0] ev_raw,
    input  logic         ev_alt,
    input  logic         sel,
    output logic [W-1:0] ev_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == SHARE_B) begin : g_shared
            assign ev_out[i] = sel ? ev_alt : ev_raw[i];
        end else begin : g_plain
            assign ev_out[i] = ev_raw[i];
        end
    end
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_in,
    input  logic         rd_clr,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat[i] <= 1'b0;
            end else if (ev_in[i]) begin
                stat[i] <= 1'b1;
            end else if (rd_clr) begin
                stat[i] <= 1'b0;
            end
        end

        // R2 and R6: an event always leaves its flag set
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ev_in[i] |=> stat[i]);
    end

    // R5: a read with no new event empties the register
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev_in == '0) |=> stat == '0);

    // R10: without a read, no flag ever drops
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(stat) & ~stat) == '0));
endmodule

// File: rtl/hdlc_irq_enable.sv
module hdlc_irq_enable
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] enable
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (wr_en) begin
            enable <= wdata;
        end
    end

    // R7: a write lands in the register on the next edge
    a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> enable == $past(wdata));

    // R7: without a write the register holds
    a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable));
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
    import hdlc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_pulse,
    input  logic              ev_tx_underrun,
    input  logic              src_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq
);
    stat_vec_t ev_sel;
    stat_vec_t stat_q;
    stat_vec_t enable_q;
    logic      rd_status;
    logic      wr_enable;

    assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);
    assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);

    hdlc_irq_src_mux #(.W(STAT_W), .SHARE_B(SHARED_BIT)) u_mux (
        .ev_raw (ev_pulse),
        .ev_alt (ev_tx_underrun),
        .sel    (src_sel),
        .ev_out (ev_sel)
    );

    hdlc_irq_status #(.W(STAT_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_in  (ev_sel),
        .rd_clr (rd_status),
        .stat   (stat_q)
    );

    hdlc_irq_enable #(.W(STAT_W)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_enable),
        .wdata  (reg_wdata),
        .enable (enable_q)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata = stat_q;
            default:     reg_rdata = enable_q;
        endcase
    end

    assign irq = |(stat_q & enable_q);

    // R3: with select low an underrun alone never sets the shared bit
    a_r3_underrun_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && ev_tx_underrun && !ev_pulse[SHARED_BIT] && !stat_q[SHARED_BIT])
        |=> !stat_q[SHARED_BIT]);

    // R4: with select high an abort alone never sets the shared bit
    a_r4_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && ev_pulse[SHARED_BIT] && !ev_tx_underrun && !stat_q[SHARED_BIT])
        |=> !stat_q[SHARED_BIT]);

    // R8: with every source disabled no interrupt is raised
    a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq);

    // R9: the interrupt holds until a status read or an enable write
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_status && !wr_enable) |=> irq);

    // R10: a status-address write leaves the enable register alone
    a_r10_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STATUS) |=> $stable(enable_q));
endmodule

// File: tb/tb_hdlc_irq_ctrl.sv
module tb_hdlc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_pulse = '0;
    logic       ev_tx_underrun = 1'b0;
    logic       src_sel = 1'b0;
    logic [0:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hdlc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse),
        .ev_tx_underrun(ev_tx_underrun), .src_sel(src_sel),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {ev[7:0], underrun, sel, enable[7:0], expected status[7:0], expected irq}
    localparam logic [26:0] VEC [10] = '{
        {8'h80, 1'b0, 1'b0, 8'hFF, 8'h80, 1'b1},
        {8'h41, 1'b0, 1'b0, 8'h01, 8'h41, 1'b1},
        {8'h04, 1'b0, 1'b0, 8'h04, 8'h04, 1'b1},
        {8'h00, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0},
        {8'h00, 1'b1, 1'b1, 8'h04, 8'h04, 1'b1},
        {8'h04, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0},
        {8'h3A, 1'b0, 1'b0, 8'h00, 8'h3A, 1'b0},
        {8'hFF, 1'b0, 1'b0, 8'h80, 8'hFF, 1'b1},
        {8'h18, 1'b0, 1'b0, 8'h24, 8'h18, 1'b0},
        {8'h22, 1'b0, 1'b0, 8'h20, 8'h22, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e, input logic u);
        ev_pulse = e; ev_tx_underrun = u;
        tick();
        ev_pulse = '0; ev_tx_underrun = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset values
        reg_addr = 1'b1; #1 check("R1 status", reg_rdata, 8'h00);
        reg_addr = 1'b0; #1 check("R1 enable", reg_rdata, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2/R3/R4/R7/R8/R9 vector walk
        for (int k = 0; k < 10; k++) begin
            logic [26:0] v;
            v = VEC[k];
            src_sel = v[17];
            reg_write(1'b0, v[16:9]);
            reg_read(1'b0, rd);
            check($sformatf("R7 enable readback vec %0d", k), rd, v[16:9]);
            reg_read(1'b1, rd);
            pulse(v[26:19], v[18]);
            check($sformatf("R9 irq vec %0d", k), {7'b0, irq}, {7'b0, v[0]});
            reg_read(1'b1, rd);
            check($sformatf("R2/R3/R4/R8 status vec %0d", k), rd, v[8:1]);
            reg_read(1'b1, rd);
            check($sformatf("R5 cleared vec %0d", k), rd, 8'h00);
            check($sformatf("R9 irq dropped vec %0d", k), {7'b0, irq}, 8'h00);
        end
        src_sel = 1'b0;

        // R9: irq stays high over idle cycles
        reg_write(1'b0, 8'h01);
        pulse(8'h01, 1'b0);
        repeat (5) tick();
        check("R9 irq held", {7'b0, irq}, 8'h01);

        // R5: read returns pre-clear value
        reg_read(1'b1, rd);
        check("R5 pre-clear value", rd, 8'h01);
        check("R5 irq after read", {7'b0, irq}, 8'h00);

        // R6: event coincident with read survives
        pulse(8'h10, 1'b0);
        ev_pulse = 8'h02;
        reg_read(1'b1, rd);
        ev_pulse = '0;
        check("R6 read value", rd, 8'h10);
        reg_read(1'b1, rd);
        check("R6 coincident event kept", rd, 8'h02);

        // R10: status write ignored, enable read does not clear
        pulse(8'h44, 1'b0);
        reg_write(1'b1, 8'h00);
        reg_read(1'b0, rd);
        check("R10 enable unchanged", rd, 8'h01);
        reg_read(1'b1, rd);
        check("R10 status unaffected by write and enable read", rd, 8'h44);

        // R1: reset clears both registers mid-run
        reg_write(1'b0, 8'hFF);
        pulse(8'h0F, 1'b0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        reg_addr = 1'b1; #1 check("R1 status after reset", reg_rdata, 8'h00);
        reg_addr = 1'b0; #1 check("R1 enable after reset", reg_rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule